// File: doc/BRIEF.md
# Instruction Fetch and Call Unit

This block holds the program counter of a 16-bit, word-addressed stack processor. The counter drives the program-memory address lines directly, so an instruction can be fetched while the data side of the machine is busy. Program memory holds 64K words of 16 bits and is only ever read as whole words. When the sequencer asks for a fetch, the word read back is sorted into one of two kinds. An operation word has all eight upper bits set, and its low byte is handed on as an opcode. Any other word is a subroutine call whose target is the full 16-bit word.

For a call, a link register captures the address of the call word before the counter jumps to the target. One cycle later the captured value is offered on a push port toward the return stack. For a return, the popped address plus one becomes the new counter in a single step. Three more commands cover the rest of the program flow:
- A conditional branch reads its target from the word that follows the branch. A taken branch jumps to that target. A branch that is not taken steps over it.
- A data access overwrites the counter with a data address and saves the old value in the link register.
- A restore command loads the saved value back into the counter.

The microcode sequencer that issues the commands and the ALU are outside this block.

Top module: `fetchu_top`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears `mem_addr` to 0x0000 and holds `op_valid` and `push_valid` low on the following cycle.
- R2: Command FETCH (`cmd`=1) on a word whose bits [15:8] are 0xFF raises `op_valid` for one cycle after the edge. In that cycle `op_code` equals bits [7:0] of the word, `mem_addr` has advanced by one, and `push_valid` stays low.
- R3: FETCH on any word whose bits [15:8] are not all ones (for example 0xFEFF or 0x00FF) loads `mem_addr` with the whole word. In the next cycle `push_valid` is high for one cycle, `push_data` equals the address the call was fetched from, and `op_valid` stays low.
- R4: Command RETURN (`cmd`=2) loads `mem_addr` with `pop_addr` + 1, modulo 2^16, so 0xFFFF wraps to 0x0000.
- R5: Command BRANCH (`cmd`=3) with `br_taken` high loads `mem_addr` with the word on `mem_rdata`.
- R6: BRANCH with `br_taken` low advances `mem_addr` by one, which steps over the target word.
- R7: Command DATA (`cmd`=4) loads `mem_addr` with `data_addr` and saves the previous `mem_addr` in the link register.
- R8: Command RESTORE (`cmd`=5) loads `mem_addr` with the link register. This is the value saved by the most recent DATA command or call.
- R9: Command IDLE (`cmd`=0), and the unused codes 6 and 7, leave `mem_addr` and the link register unchanged and raise neither `op_valid` nor `push_valid`.
- R10: `op_valid` and `push_valid` are never high in the same cycle, and each one is high only in the cycle right after a FETCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command: 0 idle, 1 fetch, 2 return, 3 branch, 4 data, 5 restore, 6 and 7 idle |
| mem_rdata | input | 16 | Word read from program memory at `mem_addr` |
| pop_addr | input | 16 | Address popped from the return stack |
| data_addr | input | 16 | Data address for a load or store |
| br_taken | input | 1 | Branch condition, sampled with BRANCH |
| mem_addr | output | 16 | Program counter, drives program-memory address |
| op_valid | output | 1 | One-cycle pulse: an operation word was fetched |
| op_code | output | 8 | Opcode of that operation word |
| push_valid | output | 1 | One-cycle pulse: push `push_data` to the return stack |
| push_data | output | 16 | Saved call address |

## Verification
The bench checks the edge of the classification rule:
- 0xFEFF must be taken as a call. A decoder that only looked at some of the upper bits would report an opcode instead.
- 0xFFFF must be taken as an operation with opcode 0xFF.

It also checks the carry when a return of 0xFFFF wraps to 0x0000. A missing increment would send execution back onto the call itself.

For a call, the bench checks that the pushed value is the address of the call word and not the target. It follows a call at once with a data access, which rewrites the link register in the very cycle of the push. It then runs a data access followed by a restore, so a link register that failed to capture the counter would return to the wrong place. A long mixed run of commands compares the unit against a behavioural model on every cycle.

// File: rtl/fetchu_pkg.sv
package fetchu_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 8;

    typedef enum logic [2:0] {
        CMD_IDLE    = 3'd0,
        CMD_FETCH   = 3'd1,
        CMD_RET     = 3'd2,
        CMD_BRANCH  = 3'd3,
        CMD_DATA    = 3'd4,
        CMD_RESTORE = 3'd5
    } cmd_e;

    // Result of sorting one instruction word
    typedef struct packed {
        logic             is_op;
        logic [OPC_W-1:0] opc;
    } decode_t;

    // Control produced by next-PC selection
    typedef struct packed {
        logic is_fetch_op;
        logic is_call;
        logic save_ld;
    } step_t;

endpackage

// File: rtl/fetchu_classify.sv
module fetchu_classify
    import fetchu_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int O = OPC_W
) (
    input  logic [W-1:0] word,
    output decode_t      dec
);
    localparam int PFX_W = W - O;

    logic [PFX_W-1:0] prefix;

    assign prefix    = word[W-1:O];
    assign dec.is_op = &prefix;
    assign dec.opc   = word[O-1:0];

endmodule

// File: rtl/fetchu_next_pc.sv
module fetchu_next_pc
    import fetchu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [2:0]   cmd,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] link,
    input  logic [W-1:0] word,
    input  logic [W-1:0] pop_addr,
    input  logic [W-1:0] data_addr,
    input  logic         taken,
    input  logic         word_is_op,
    output logic [W-1:0] pc_nxt,
    output step_t        step
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    cmd_e c;
    assign c = cmd_e'(cmd);

    always_comb begin
        pc_nxt = pc;
        step   = '0;
        case (c)
            CMD_FETCH: begin
                if (word_is_op) begin
                    step.is_fetch_op = 1'b1;
                    pc_nxt           = pc + ONE;
                end else begin
                    step.is_call = 1'b1;
                    step.save_ld = 1'b1;
                    pc_nxt       = word;
                end
            end
            CMD_RET:     pc_nxt = pop_addr + ONE;
            CMD_BRANCH:  pc_nxt = taken ? word : pc + ONE;
            CMD_DATA: begin
                step.save_ld = 1'b1;
                pc_nxt       = data_addr;
            end
            CMD_RESTORE: pc_nxt = link;
            default:     pc_nxt = pc;
        endcase
    end

endmodule

// File: rtl/fetchu_link.sv
module fetchu_link
    import fetchu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         save_ld,
    input  logic         call,
    input  logic [W-1:0] pc,
    output logic [W-1:0] link,
    output logic         push_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            link       <= '0;
            push_valid <= 1'b0;
        end else begin
            push_valid <= call;
            if (save_ld) begin
                link <= pc;
            end
        end
    end

    // R3: the value offered for push is the address the call came from
    p_push_src_r3: assert property (@(posedge clk) disable iff (rst)
        call |=> (push_valid && link == $past(pc)));

endmodule

// File: rtl/fetchu_top.sv
module fetchu_top
    import fetchu_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int O = OPC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   cmd,
    input  logic [W-1:0] mem_rdata,
    input  logic [W-1:0] pop_addr,
    input  logic [W-1:0] data_addr,
    input  logic         br_taken,
    output logic [W-1:0] mem_addr,
    output logic         op_valid,
    output logic [O-1:0] op_code,
    output logic         push_valid,
    output logic [W-1:0] push_data
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] pc_q;
    logic [W-1:0] pc_nxt;
    logic [W-1:0] link;
    decode_t      dec;
    step_t        step;

    fetchu_classify #(.W(W), .O(O)) u_cls (
        .word (mem_rdata),
        .dec  (dec)
    );

    fetchu_next_pc #(.W(W)) u_npc (
        .cmd        (cmd),
        .pc         (pc_q),
        .link       (link),
        .word       (mem_rdata),
        .pop_addr   (pop_addr),
        .data_addr  (data_addr),
        .taken      (br_taken),
        .word_is_op (dec.is_op),
        .pc_nxt     (pc_nxt),
        .step       (step)
    );

    fetchu_link #(.W(W)) u_link (
        .clk        (clk),
        .rst        (rst),
        .save_ld    (step.save_ld),
        .call       (step.is_call),
        .pc         (pc_q),
        .link       (link),
        .push_valid (push_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            op_valid <= 1'b0;
            op_code  <= '0;
        end else begin
            pc_q     <= pc_nxt;
            op_valid <= step.is_fetch_op;
            if (step.is_fetch_op) begin
                op_code <= dec.opc;
            end
        end
    end

    assign mem_addr  = pc_q;
    assign push_data = link;

    // R2: an all-ones upper byte yields an opcode and a one-word advance
    p_fetch_op_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd1 && mem_rdata[W-1:O] == {(W-O){1'b1}})
        |=> (op_valid && !push_valid && op_code == $past(mem_rdata[O-1:0])
             && mem_addr == $past(mem_addr) + ONE));

    // R3: any other fetched word is a jump target
    p_call_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd1 && mem_rdata[W-1:O] != {(W-O){1'b1}})
        |=> (mem_addr == $past(mem_rdata) && !op_valid));

    // R4: return lands one past the popped address
    p_ret_inc_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2) |=> (mem_addr == $past(pop_addr) + ONE));

    // R9: idle holds the counter
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd0 || cmd == 3'd6 || cmd == 3'd7) |=> $stable(mem_addr));

    // R10: the two pulses never coincide
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && push_valid));

endmodule

// File: tb/tb_fetchu_top.sv
module tb_fetchu_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd = 3'd0;
    logic [15:0] mem_rdata = 16'h0;
    logic [15:0] pop_addr = 16'h0;
    logic [15:0] data_addr = 16'h0;
    logic        br_taken = 1'b0;
    logic [15:0] mem_addr;
    logic        op_valid;
    logic [7:0]  op_code;
    logic        push_valid;
    logic [15:0] push_data;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [15:0] m_pc   = 16'h0;
    logic [15:0] m_link = 16'h0;
    logic        m_opv  = 1'b0;
    logic [7:0]  m_opc  = 8'h0;
    logic        m_pv   = 1'b0;
    logic [15:0] m_pd   = 16'h0;
    string       pend   = "R1";

    always #10 clk = ~clk;

    fetchu_top dut (
        .clk(clk), .rst(rst), .cmd(cmd), .mem_rdata(mem_rdata),
        .pop_addr(pop_addr), .data_addr(data_addr), .br_taken(br_taken),
        .mem_addr(mem_addr), .op_valid(op_valid), .op_code(op_code),
        .push_valid(push_valid), .push_data(push_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic compare();
        chk(pend, "mem_addr", mem_addr, m_pc);
        chk(pend, "op_valid", {15'h0, op_valid}, {15'h0, m_opv});
        chk(pend, "push_valid", {15'h0, push_valid}, {15'h0, m_pv});
        if (m_opv) chk(pend, "op_code", {8'h0, op_code}, {8'h0, m_opc});
        if (m_pv)  chk(pend, "push_data", push_data, m_pd);
    endtask

    // compare the result of the previous command, then apply a new one
    task automatic step(input logic [2:0] c, input logic [15:0] rd,
                        input logic [15:0] pa, input logic [15:0] da,
                        input logic bt, input string req);
        @(negedge clk);
        compare();
        cmd = c; mem_rdata = rd; pop_addr = pa; data_addr = da; br_taken = bt;
        m_opv = 1'b0;
        m_pv  = 1'b0;
        case (c)
            3'd1: begin
                if (rd[15:8] == 8'hFF) begin
                    m_opv = 1'b1; m_opc = rd[7:0]; m_pc = m_pc + 16'd1;
                end else begin
                    m_pv = 1'b1; m_pd = m_pc; m_link = m_pc; m_pc = rd;
                end
            end
            3'd2: m_pc = pa + 16'd1;
            3'd3: m_pc = bt ? rd : m_pc + 16'd1;
            3'd4: begin m_link = m_pc; m_pc = da; end
            3'd5: m_pc = m_link;
            default: ;
        endcase
        pend = req;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state checked by the first compare
        step(3'd1, 16'hFF12, 16'h0, 16'h0, 1'b0, "R2");
        step(3'd1, 16'hFFFF, 16'h0, 16'h0, 1'b0, "R2");
        step(3'd1, 16'hFEFF, 16'h0, 16'h0, 1'b0, "R3");
        step(3'd0, 16'h1111, 16'h2222, 16'h3333, 1'b1, "R9");
        step(3'd1, 16'h1234, 16'h0, 16'h0, 1'b0, "R3");
        step(3'd2, 16'h0, 16'h0100, 16'h0, 1'b0, "R4");
        step(3'd2, 16'h0, 16'hFFFF, 16'h0, 1'b0, "R4");
        step(3'd3, 16'h4000, 16'h0, 16'h0, 1'b1, "R5");
        step(3'd3, 16'h5000, 16'h0, 16'h0, 1'b0, "R6");
        step(3'd4, 16'h0, 16'h0, 16'hABCD, 1'b0, "R7");
        step(3'd5, 16'h0, 16'h0, 16'h0, 1'b0, "R8");
        step(3'd6, 16'hFF01, 16'h7777, 16'h8888, 1'b1, "R9");
        step(3'd7, 16'h0042, 16'h7777, 16'h8888, 1'b1, "R9");
        step(3'd1, 16'h00FF, 16'h0, 16'h0, 1'b0, "R3");
        step(3'd4, 16'h0, 16'h0, 16'h0C00, 1'b0, "R7");
        step(3'd5, 16'h0, 16'h0, 16'h0, 1'b0, "R8");
        // reset in the middle of activity
        @(negedge clk);
        compare();
        cmd = 3'd1; mem_rdata = 16'hFF33; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; cmd = 3'd0;
        m_pc = 16'h0; m_link = 16'h0; m_opv = 1'b0; m_pv = 1'b0;
        pend = "R1";
        // mixed run against the model; R10 exclusivity via op/push compares
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [15:0] w;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            w = (lfsr[3]) ? {8'hFF, lfsr[15:8]} : {lfsr[7:0], lfsr[15:8]};
            step(lfsr[2:0], w, {lfsr[7:0], lfsr[15:8]}, lfsr ^ 16'h5A5A,
                 lfsr[9], "R10");
        end
        step(3'd0, 16'h0, 16'h0, 16'h0, 1'b0, "R9");
        @(negedge clk);
        compare();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule